// File: doc/BRIEF.md
# Thermal Assertion Duration Accumulator

This block measures how long an active-low over-temperature input has been held low, adding up the time across separate episodes. The input is first passed through a synchronizer. An 8-bit accumulated-time counter grows by one on each time-base tick while the input is asserted. It keeps its value while the input is released. Reading the counter clears it. If the read happens while the input is still asserted, the counter restarts from one, because an episode is still in progress.

A programmable 8-bit limit is compared with the counter. Once the counter is strictly greater than the limit, a sticky status flag at bit 5 of the status word is set. The flag stays set until software writes a 1 to that bit. The active-low alert output follows the flag unless a mask bit is set. The time base is either an external tick-enable pulse or an internal prescaler, chosen by a parameter.

Top module: `thermacc`

## Requirements
- R1: After reset the timer reads 0x00, the status word reads 0x00, the limit reads 0x00, the mask reads 0 and `alert_n` is high.
- R2: When the synchronized assertion is seen and the counter holds zero, the counter becomes 0x01. This happens on the third rising clock edge after `therm_n` falls.
- R3: While the input is asserted, each clock with `tick_in` high adds one to the counter. While the input is released, ticks are ignored and the counter keeps its value.
- R4: Consider a clock with `rd_timer` high while the input is released. During that clock `timer_q` shows the held value, and after the edge the counter is 0x00.
- R5: Consider a clock with `rd_timer` high while the input is asserted. After the edge the counter is 0x01, and later ticks count upward from there.
- R6: Status bit 5 (`status_q` = 0x20) is set one clock after the counter becomes strictly greater than the limit. A counter equal to the limit does not set it.
- R7: The status flag stays set after the counter is cleared or the condition goes away.
- R8: A status write with bit 5 of `stat_wdata` set clears the flag. A status write with bit 5 clear has no effect on it.
- R9: If a clear write and a counter-above-limit condition occur in the same clock, the flag stays set.
- R10: `alert_n` is low exactly when the flag is set and the mask is 0. With the mask at 1, `alert_n` stays high while the flag still sets and reads back as 0x20.
- R11: A limit of 0x00 sets the flag on the first assertion, with no tick needed. A limit of 0x01 needs one tick beyond the first seed.
- R12: The counter saturates at 0xFF and never wraps to zero, however many further ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_n | input | 1 | Asynchronous active-low over-temperature input |
| tick_in | input | 1 | External time-base enable, one LSB of time per pulse |
| rd_timer | input | 1 | Timer read strobe; clears the counter at the edge |
| timer_q | output | 8 | Accumulated-time counter value |
| lim_we | input | 1 | Limit register write enable |
| lim_wdata | input | 8 | Limit write data |
| limit_q | output | 8 | Limit register value |
| mask_we | input | 1 | Mask bit write enable |
| mask_wdata | input | 1 | Mask write data, 1 suppresses the alert |
| mask_q | output | 1 | Mask bit value |
| stat_we | input | 1 | Status write strobe, bit 5 is write-1-to-clear |
| stat_wdata | input | 8 | Status write data |
| status_q | output | 8 | Status word, bit 5 is the over-limit flag |
| alert_n | output | 1 | Active-low level alert |

## Verification
The assertions check on every clock the following rules. The counter never wraps once it is saturated, and it holds while the input is released. A read reloads the counter with 0 or 1, depending on the assertion state. An above-limit counter is always followed by a set flag, the flag only falls after a clear write, and a set mask always keeps the alert high. Some behaviour only the bench scenarios can show. This covers the synchronizer latency before the first seed, and accumulation summed across two separate episodes. It also covers the strict versus equal limit boundary, the zero and one limit cases, and a write of zero leaving the flag alone.

// File: rtl/thermacc_pkg.sv
package thermacc_pkg;

    localparam int STATUS_FLAG_BIT = 5;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_SEED  = 2'd2,
        CNT_INC   = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic active;
        logic tick;
        logic rd;
    } cnt_ctrl_t;

    function automatic cnt_op_e pick_op(input cnt_ctrl_t c, input logic is_zero,
                                        input logic is_max);
        cnt_op_e op;
        if (c.rd)
            op = c.active ? CNT_SEED : CNT_CLEAR;
        else if (!c.active)
            op = CNT_HOLD;
        else if (is_zero)
            op = CNT_SEED;
        else if (c.tick && !is_max)
            op = CNT_INC;
        else
            op = CNT_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/thermacc_sync.sv
module thermacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= 1'b0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/thermacc_tickgen.sv
module thermacc_tickgen #(
    parameter bit USE_EXT_TICK = 1'b1,
    parameter int PRESCALE_DIV = 1138000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic tick
);
    localparam int PW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE_DIV - 1);

    generate
        if (USE_EXT_TICK) begin : g_ext
            assign tick = tick_in;
        end else begin : g_int
            logic unused_tick_in;
            logic [PW-1:0] div_q;
            assign unused_tick_in = tick_in;
            always_ff @(posedge clk) begin
                if (rst)                div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/thermacc_counter.sv
module thermacc_counter
    import thermacc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctrl_t    ctrl,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_op_e op;

    always_comb op = pick_op(ctrl, (cnt_q == '0), (&cnt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_CLEAR: cnt_q <= '0;
                CNT_SEED:  cnt_q <= ONE;
                CNT_INC:   cnt_q <= cnt_q + ONE;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/thermacc_flag.sv
module thermacc_flag #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic         lim_we,
    input  logic [W-1:0] lim_wdata,
    input  logic         mask_we,
    input  logic         mask_wdata,
    input  logic         clr_req,
    output logic [W-1:0] limit_q,
    output logic         mask_q,
    output logic         flag_q,
    output logic         alert_n
);
    logic exceed;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
            mask_q  <= 1'b0;
        end else begin
            if (lim_we)  limit_q <= lim_wdata;
            if (mask_we) mask_q  <= mask_wdata;
        end
    end

    assign exceed = (cnt > limit_q);

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (exceed)  flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assign alert_n = ~(flag_q & ~mask_q);
endmodule

// File: rtl/thermacc.sv
module thermacc
    import thermacc_pkg::*;
#(
    parameter int TIMER_W      = 8,
    parameter int SYNC_STAGES  = 2,
    parameter bit USE_EXT_TICK = 1'b1,
    parameter int PRESCALE_DIV = 1138000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               therm_n,
    input  logic               tick_in,
    input  logic               rd_timer,
    output logic [TIMER_W-1:0] timer_q,
    input  logic               lim_we,
    input  logic [TIMER_W-1:0] lim_wdata,
    output logic [TIMER_W-1:0] limit_q,
    input  logic               mask_we,
    input  logic               mask_wdata,
    output logic               mask_q,
    input  logic               stat_we,
    input  logic [7:0]         stat_wdata,
    output logic [7:0]         status_q,
    output logic               alert_n
);
    logic      sync_active;
    logic      tick;
    logic      flag;
    logic      clr_req;
    cnt_ctrl_t ctrl;

    thermacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (~therm_n),
        .dout(sync_active)
    );

    thermacc_tickgen #(.USE_EXT_TICK(USE_EXT_TICK), .PRESCALE_DIV(PRESCALE_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_in(tick_in),
        .tick   (tick)
    );

    always_comb begin
        ctrl.active = sync_active;
        ctrl.tick   = tick;
        ctrl.rd     = rd_timer;
    end

    thermacc_counter #(.W(TIMER_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .cnt_q(timer_q)
    );

    assign clr_req = stat_we & stat_wdata[STATUS_FLAG_BIT];

    thermacc_flag #(.W(TIMER_W)) u_flag (
        .clk       (clk),
        .rst       (rst),
        .cnt       (timer_q),
        .lim_we    (lim_we),
        .lim_wdata (lim_wdata),
        .mask_we   (mask_we),
        .mask_wdata(mask_wdata),
        .clr_req   (clr_req),
        .limit_q   (limit_q),
        .mask_q    (mask_q),
        .flag_q    (flag),
        .alert_n   (alert_n)
    );

    always_comb begin
        status_q = '0;
        status_q[STATUS_FLAG_BIT] = flag;
    end
endmodule

// File: rtl/thermacc_chk.sv
module thermacc_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         active,
    input logic         rd,
    input logic [W-1:0] cnt,
    input logic [W-1:0] limit,
    input logic         flag,
    input logic         clr,
    input logic         mask,
    input logic         alert_n
);
    // R12
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (&cnt && !rd) |=> (&cnt));

    // R3
    hold_released_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !rd) |=> $stable(cnt));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !active) |=> (cnt == '0));

    // R5
    read_reseed_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && active) |=> (cnt == W'(1)));

    // R6
    exceed_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt > limit) |=> flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R10
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mask |-> alert_n);
endmodule

bind thermacc thermacc_chk #(.W(TIMER_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .active (sync_active),
    .rd     (rd_timer),
    .cnt    (timer_q),
    .limit  (limit_q),
    .flag   (flag),
    .clr    (clr_req),
    .mask   (mask_q),
    .alert_n(alert_n)
);

// File: tb/thermacc_test.sv
module thermacc_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       therm_n = 1'b1;
    logic       tick_in = 1'b0;
    logic       rd_timer = 1'b0;
    logic [7:0] timer_q;
    logic       lim_we = 1'b0;
    logic [7:0] lim_wdata = 8'h00;
    logic [7:0] limit_q;
    logic       mask_we = 1'b0;
    logic       mask_wdata = 1'b0;
    logic       mask_q;
    logic       stat_we = 1'b0;
    logic [7:0] stat_wdata = 8'h00;
    logic [7:0] status_q;
    logic       alert_n;

    always #10 clk = ~clk;

    thermacc uut (
        .clk(clk), .rst(rst), .therm_n(therm_n), .tick_in(tick_in),
        .rd_timer(rd_timer), .timer_q(timer_q), .lim_we(lim_we),
        .lim_wdata(lim_wdata), .limit_q(limit_q), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .mask_q(mask_q), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .status_q(status_q), .alert_n(alert_n)
    );

    typedef struct {
        string req;
        int    sel;
        int    exp;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;

    // monitor: pops expectations and compares with the ports
    initial begin
        forever begin
            wait (q.size() != 0);
            begin
                item_t it;
                int    act;
                it = q.pop_front();
                case (it.sel)
                    0: act = int'(timer_q);
                    1: act = int'(status_q);
                    2: act = int'(alert_n);
                    3: act = int'(limit_q);
                    default: act = int'(mask_q);
                endcase
                n_checks++;
                if (act != it.exp) begin
                    n_errors++;
                    $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h",
                             it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input string req, input int sel, input int exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
        #1;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        tick_in = 1'b1;
        step(n);
        tick_in = 1'b0;
    endtask

    task automatic read_timer();
        rd_timer = 1'b1;
        step(1);
        rd_timer = 1'b0;
    endtask

    task automatic write_limit(input logic [7:0] v);
        lim_we = 1'b1; lim_wdata = v;
        step(1);
        lim_we = 1'b0;
    endtask

    task automatic write_mask(input logic v);
        mask_we = 1'b1; mask_wdata = v;
        step(1);
        mask_we = 1'b0;
    endtask

    task automatic write_status(input logic [7:0] v);
        stat_we = 1'b1; stat_wdata = v;
        step(1);
        stat_we = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        expect_val("R1", 0, 8'h00);
        expect_val("R1", 1, 8'h00);
        expect_val("R1", 2, 1);
        expect_val("R1", 3, 8'h00);
        expect_val("R1", 4, 0);

        write_limit(8'h10);
        // R2 seed after synchronizer latency
        therm_n = 1'b0;
        step(2);
        expect_val("R2", 0, 8'h00);
        step(1);
        expect_val("R2", 0, 8'h01);
        // R3 accumulation and hold
        tick_n(3);
        expect_val("R3", 0, 8'h04);
        therm_n = 1'b1;
        step(3);
        tick_n(5);
        expect_val("R3", 0, 8'h04);
        therm_n = 1'b0;
        step(3);
        expect_val("R3", 0, 8'h04);
        tick_n(2);
        expect_val("R3", 0, 8'h06);
        therm_n = 1'b1;
        step(3);

        // R4 read while released
        rd_timer = 1'b1;
        expect_val("R4", 0, 8'h06);
        step(1);
        rd_timer = 1'b0;
        expect_val("R4", 0, 8'h00);

        // R5 read while asserted
        therm_n = 1'b0;
        step(3);
        tick_n(2);
        expect_val("R5", 0, 8'h03);
        read_timer();
        expect_val("R5", 0, 8'h01);
        tick_n(1);
        expect_val("R5", 0, 8'h02);

        // R6 strict compare
        therm_n = 1'b1;
        step(3);
        read_timer();
        write_limit(8'h03);
        therm_n = 1'b0;
        step(3);
        tick_n(2);
        step(1);
        expect_val("R6", 0, 8'h03);
        expect_val("R6", 1, 8'h00);
        tick_n(1);
        step(1);
        expect_val("R6", 1, 8'h20);
        expect_val("R6", 2, 0);

        // R7 sticky after counter cleared
        therm_n = 1'b1;
        step(3);
        read_timer();
        step(1);
        expect_val("R7", 0, 8'h00);
        expect_val("R7", 1, 8'h20);

        // R8 write zero ignored, write one clears
        write_status(8'hDF);
        expect_val("R8", 1, 8'h20);
        write_status(8'h20);
        expect_val("R8", 1, 8'h00);
        expect_val("R8", 2, 1);

        // R11 zero limit flags first assertion
        write_limit(8'h00);
        step(1);
        expect_val("R11", 1, 8'h00);
        therm_n = 1'b0;
        step(3);
        step(1);
        expect_val("R11", 1, 8'h20);

        // R9 set wins over clear
        write_status(8'h20);
        expect_val("R9", 1, 8'h20);

        // R10 mask
        write_mask(1'b1);
        expect_val("R10", 2, 1);
        expect_val("R10", 1, 8'h20);
        expect_val("R10", 4, 1);
        write_mask(1'b0);
        expect_val("R10", 2, 0);

        // R11 limit of one
        therm_n = 1'b1;
        step(3);
        read_timer();
        write_limit(8'h01);
        write_status(8'h20);
        expect_val("R11", 1, 8'h00);
        therm_n = 1'b0;
        step(3);
        step(1);
        expect_val("R11", 0, 8'h01);
        expect_val("R11", 1, 8'h00);
        tick_n(1);
        step(1);
        expect_val("R11", 1, 8'h20);

        // R12 saturation
        write_limit(8'hFF);
        read_timer();
        write_status(8'h20);
        expect_val("R12", 0, 8'h01);
        expect_val("R12", 1, 8'h00);
        tick_n(300);
        expect_val("R12", 0, 8'hFF);
        step(1);
        expect_val("R12", 1, 8'h00);
        expect_val("R12", 3, 8'hFF);

        step(2);
        done = 1'b1;
        report();
    end
endmodule